// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block follows the memory footprint of one hardware transaction. It records each cache line the transaction touches and notes whether the line was read, written, or both. It also watches coherence snoops from other agents. When a snoop collides with the footprint, when a set runs out of ways, when software aborts explicitly, or when a debug breakpoint fires, the block ends the transaction. It then reports why, using a fixed 32-bit abort status word. A transaction that reaches its outermost end command commits instead.

Lines are 64 bytes. The set index is address bits [11:6], which gives 64 sets of 8 ways each. Every way holds one tag with a read mark and a write mark. The block supports nesting up to a depth of 7. A load-tracking suspend input lets code inside a transaction read memory without adding those lines to the read set. Data buffering, register checkpoints and the coherence protocol itself sit outside this block.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset `in_txn_o`, `abort_o`, `commit_o` and `abort_status_o` are all zero. A `begin_i` seen while idle raises `in_txn_o` on the next cycle, and `in_txn_o` stays high until the cycle in which `commit_o` or `abort_o` is high.
- R2: Each `begin_i` adds one to a nesting depth and each `end_i` subtracts one. `commit_o` pulses for one cycle, one cycle after the `end_i` that brings the depth to zero. An inner `end_i` gives no commit, and an `end_i` while idle is ignored.
- R3: Tracking works on 64-byte lines. The set index is address bits [11:6] and the tag is the bits above bit 11. Any byte address inside a tracked line hits that line. A new line takes the lowest free of the 8 ways in its set. Touching a line again takes no new way.
- R4: A tracked access that needs a new line in a set whose 8 ways are all in use aborts the transaction. The status word has bit 3 (overflow) and bit 1 (retry may succeed) set, which is 0x0000000A at depth 1.
- R5: A snooped write to a line in the read set or the write set aborts the transaction. So does a snooped read of a line in the write set. Either case sets bit 2 (conflict) and bit 1, giving 0x00000006 at depth 1. A snooped read of a line that was only read, or any snoop to an untracked line, has no effect.
- R6: `abort_i` sets status bit 0 and copies `abort_code_i` into bits 31:24. Bit 1 is then clear. For every abort without `abort_i`, bits 31:24 are zero.
- R7: `debug_hit_i` during a transaction aborts it with bit 4 set and bit 1 clear.
- R8: An abort taken at a nesting depth of 2 or more also sets bit 5.
- R9: When several abort causes occur in the same cycle, every matching cause bit is set. Bit 1 is set only if a conflict or overflow cause is present and no explicit abort is. Bits 23:6 are always zero.
- R10: While `trk_suspend_i` is high, local loads add nothing to the read set and take no ways. Stores are still tracked. Lines tracked before the suspend began stay tracked, so a snooped write to such a line still aborts the transaction.
- R11: Every abort and every commit clears all tags at once. A line from an earlier transaction causes no conflict in the next one, and all 8 ways of each set are free again.
- R12: `abort_o` and `abort_status_o` are registered. They are valid for exactly one cycle, one cycle after the cause. `abort_status_o` is zero in every other cycle. A `begin_i` in the cycle where `abort_o` is high starts a new transaction.
- R13: While no transaction is active, accesses, snoops, `abort_i`, `debug_hit_i` and `end_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | 1 | Begin command (opens a transaction or nests one level deeper) |
| end_i | input | 1 | End command (closes one nesting level) |
| abort_i | input | 1 | Explicit abort command |
| abort_code_i | input | 8 | Argument of the explicit abort |
| acc_valid_i | input | 1 | Local access is valid this cycle |
| acc_write_i | input | 1 | Local access is a store (1) or a load (0) |
| acc_addr_i | input | 32 | Byte address of the local access |
| trk_suspend_i | input | 1 | While high, local loads are not tracked |
| snp_valid_i | input | 1 | Snooped remote access is valid this cycle |
| snp_write_i | input | 1 | Snooped access is a write (1) or a read (0) |
| snp_addr_i | input | 32 | Byte address of the snooped access |
| debug_hit_i | input | 1 | Debug breakpoint hit pulse |
| commit_o | output | 1 | Commit pulse, one cycle |
| abort_o | output | 1 | Abort pulse, one cycle |
| abort_status_o | output | 32 | Abort status word, valid while abort_o is high |
| in_txn_o | output | 1 | High while a transaction is active |

## Verification
The properties take three things for granted about the inputs. `begin_i` and `end_i` never arrive together, and the nesting depth never passes 7. When they do arrive together, the design leaves the depth unchanged, but the properties are not written for that case. The properties also assume snoops and local accesses carry meaningful addresses only while their valid inputs are high. The stimulus keeps to these limits. It issues at most one command per cycle, nests no deeper than two, and drives address buses with a valid strobe only.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int STATUS_W    = 32;
  localparam int CODE_W      = 8;
  localparam int ST_SW       = 0;
  localparam int ST_RETRY    = 1;
  localparam int ST_CONF     = 2;
  localparam int ST_OVF      = 3;
  localparam int ST_DBG      = 4;
  localparam int ST_NEST     = 5;
  localparam int ST_CODE_LSB = 24;

  typedef struct packed {
    logic sw;
    logic conf;
    logic ovf;
    logic dbg;
  } cause_t;

  function automatic logic [STATUS_W-1:0] pack_status(input cause_t c,
                                                      input logic nested,
                                                      input logic [CODE_W-1:0] code);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[ST_SW]    = c.sw;
    s[ST_RETRY] = (c.conf | c.ovf) & ~c.sw;
    s[ST_CONF]  = c.conf;
    s[ST_OVF]   = c.ovf;
    s[ST_DBG]   = c.dbg;
    s[ST_NEST]  = nested;
    if (c.sw) s[ST_CODE_LSB +: CODE_W] = code;
    return s;
  endfunction
endpackage

// File: rtl/txn_way_match.sv
module txn_way_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [WAYS-1:0]            hit_oh_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_oh_o[w] = vld_i[w] && (tag_i[w] == key_i);
  end
endmodule

// File: rtl/txn_tag_array.sv
module txn_tag_array #(
  parameter int WAYS  = 8,
  parameter int SET_W = 6,
  parameter int TAG_W = 20,
  localparam int SETS = 1 << SET_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             upd_wr_i,
  input  logic [SET_W-1:0] loc_set_i,
  input  logic [TAG_W-1:0] loc_tag_i,
  input  logic [SET_W-1:0] snp_set_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             loc_hit_o,
  output logic             loc_full_o,
  output logic             snp_rd_o,
  output logic             snp_wr_o
);
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0]            rd_q  [SETS];
  logic [WAYS-1:0]            wr_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];

  logic [WAYS-1:0] loc_hit_oh, snp_hit_oh, loc_vld, free_oh, alloc_m;

  assign loc_vld = vld_q[loc_set_i];

  txn_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_loc_match (
    .vld_i    (loc_vld),
    .tag_i    (tag_q[loc_set_i]),
    .key_i    (loc_tag_i),
    .hit_oh_o (loc_hit_oh)
  );

  txn_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_snp_match (
    .vld_i    (vld_q[snp_set_i]),
    .tag_i    (tag_q[snp_set_i]),
    .key_i    (snp_tag_i),
    .hit_oh_o (snp_hit_oh)
  );

  // lowest clear valid bit; all ones gives zero
  assign free_oh    = ~loc_vld & (loc_vld + WAYS'(1));
  assign loc_hit_o  = |loc_hit_oh;
  assign loc_full_o = &loc_vld;
  assign alloc_m    = loc_hit_o ? loc_hit_oh : free_oh;
  assign snp_rd_o   = |(snp_hit_oh & rd_q[snp_set_i]);
  assign snp_wr_o   = |(snp_hit_oh & wr_q[snp_set_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rd_q[s]  <= '0;
        wr_q[s]  <= '0;
      end
    end else if (clr_i) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rd_q[s]  <= '0;
        wr_q[s]  <= '0;
      end
    end else if (upd_i) begin
      vld_q[loc_set_i] <= loc_vld | alloc_m;
      rd_q[loc_set_i]  <= rd_q[loc_set_i] | (alloc_m & {WAYS{~upd_wr_i}});
      wr_q[loc_set_i]  <= wr_q[loc_set_i] | (alloc_m & {WAYS{upd_wr_i}});
    end
  end

  // tags need no reset: valid bits gate them
  always_ff @(posedge clk_i) begin
    if (upd_i && !clr_i && !loc_hit_o) begin
      for (int w = 0; w < WAYS; w++) begin
        if (free_oh[w]) tag_q[loc_set_i][w] <= loc_tag_i;
      end
    end
  end
endmodule

// File: rtl/txn_abort_ctrl.sv
module txn_abort_ctrl
  import txn_pkg::*;
#(
  parameter int DEPTH_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                begin_i,
  input  logic                end_i,
  input  logic                abort_i,
  input  logic [CODE_W-1:0]   abort_code_i,
  input  logic                debug_hit_i,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic                trk_suspend_i,
  input  logic                loc_hit_i,
  input  logic                loc_full_i,
  input  logic                snp_valid_i,
  input  logic                snp_write_i,
  input  logic                snp_rd_hit_i,
  input  logic                snp_wr_hit_i,
  output logic                clr_o,
  output logic                upd_o,
  output logic                commit_o,
  output logic                abort_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                in_txn_o
);
  localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               active, need, abt, fin;
  cause_t             cause;

  assign active = depth_q != '0;
  assign need   = acc_valid_i && active && (acc_write_i || !trk_suspend_i);

  always_comb begin
    cause.sw   = active && abort_i;
    cause.conf = active && snp_valid_i &&
                 (snp_write_i ? (snp_rd_hit_i || snp_wr_hit_i) : snp_wr_hit_i);
    cause.ovf  = need && !loc_hit_i && loc_full_i;
    cause.dbg  = active && debug_hit_i;
  end

  assign abt   = |cause;
  assign fin   = active && end_i && !begin_i && !abt && (depth_q == DEPTH_W'(1));
  assign clr_o = abt || fin;
  assign upd_o = need && !abt && !fin;

  always_comb begin
    depth_d = depth_q;
    if (abt)                                          depth_d = '0;
    else if (begin_i && !end_i && depth_q != DMAX)    depth_d = depth_q + DEPTH_W'(1);
    else if (end_i && !begin_i && active)             depth_d = depth_q - DEPTH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q  <= '0;
      abort_o  <= 1'b0;
      commit_o <= 1'b0;
      status_o <= '0;
    end else begin
      depth_q  <= depth_d;
      abort_o  <= abt;
      commit_o <= fin;
      status_o <= abt ? pack_status(cause, depth_q > DEPTH_W'(1), abort_code_i) : '0;
    end
  end

  assign in_txn_o = active;
endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txn_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 6,
  parameter int SET_W   = 6,
  parameter int WAYS    = 8,
  parameter int DEPTH_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                begin_i,
  input  logic                end_i,
  input  logic                abort_i,
  input  logic [CODE_W-1:0]   abort_code_i,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic                trk_suspend_i,
  input  logic                snp_valid_i,
  input  logic                snp_write_i,
  input  logic [ADDR_W-1:0]   snp_addr_i,
  input  logic                debug_hit_i,
  output logic                commit_o,
  output logic                abort_o,
  output logic [STATUS_W-1:0] abort_status_o,
  output logic                in_txn_o
);
  localparam int TAG_W = ADDR_W - LINE_W - SET_W;

  logic [SET_W-1:0] acc_set, snp_set;
  logic [TAG_W-1:0] acc_tag, snp_tag;
  logic             clr, upd, loc_hit, loc_full, snp_rd, snp_wr;
  logic             unused_line_off;

  assign acc_set = acc_addr_i[LINE_W +: SET_W];
  assign snp_set = snp_addr_i[LINE_W +: SET_W];
  assign acc_tag = acc_addr_i[ADDR_W-1 -: TAG_W];
  assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_line_off = ^{acc_addr_i[LINE_W-1:0], snp_addr_i[LINE_W-1:0]};

  txn_tag_array #(.WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W)) i_tag_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .upd_i      (upd),
    .upd_wr_i   (acc_write_i),
    .loc_set_i  (acc_set),
    .loc_tag_i  (acc_tag),
    .snp_set_i  (snp_set),
    .snp_tag_i  (snp_tag),
    .loc_hit_o  (loc_hit),
    .loc_full_o (loc_full),
    .snp_rd_o   (snp_rd),
    .snp_wr_o   (snp_wr)
  );

  txn_abort_ctrl #(.DEPTH_W(DEPTH_W)) i_abort_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .begin_i       (begin_i),
    .end_i         (end_i),
    .abort_i       (abort_i),
    .abort_code_i  (abort_code_i),
    .debug_hit_i   (debug_hit_i),
    .acc_valid_i   (acc_valid_i),
    .acc_write_i   (acc_write_i),
    .trk_suspend_i (trk_suspend_i),
    .loc_hit_i     (loc_hit),
    .loc_full_i    (loc_full),
    .snp_valid_i   (snp_valid_i),
    .snp_write_i   (snp_write_i),
    .snp_rd_hit_i  (snp_rd),
    .snp_wr_hit_i  (snp_wr),
    .clr_o         (clr),
    .upd_o         (upd),
    .commit_o      (commit_o),
    .abort_o       (abort_o),
    .status_o      (abort_status_o),
    .in_txn_o      (in_txn_o)
  );
endmodule

// File: rtl/txn_set_tracker_chk.sv
module txn_set_tracker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        begin_i,
  input logic        end_i,
  input logic        snp_valid_i,
  input logic        commit_o,
  input logic        abort_o,
  input logic [31:0] abort_status_o,
  input logic        in_txn_o
);
  // R6
  sw_no_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && abort_status_o[0] |-> !abort_status_o[1]);
  // R6
  code_only_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && !abort_status_o[0] |-> abort_status_o[31:24] == 8'h00);
  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> abort_status_o[23:6] == '0);
  // R12
  quiet_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |-> abort_status_o == '0);
  // R12
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  // R1
  end_drops_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o || commit_o |-> !in_txn_o);
  // R1
  rise_on_begin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_txn_o) |-> $past(begin_i));
  // R2
  excl_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({abort_o, commit_o}));
  // R2
  commit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(in_txn_o) && $past(end_i));
  // R5
  conflict_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && abort_status_o[2] |-> $past(snp_valid_i));
endmodule

bind txn_set_tracker txn_set_tracker_chk i_chk (.*);

// File: tb/test_txn_set_tracker.sv
module test_txn_set_tracker;
  localparam int CLK_P = 10;
  localparam logic [31:0] S_CONF = 32'h0000_0006;
  localparam logic [31:0] S_OVF  = 32'h0000_000A;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        begin_i, end_i, abort_i, acc_valid_i, acc_write_i;
  logic        trk_suspend_i, snp_valid_i, snp_write_i, debug_hit_i;
  logic [7:0]  abort_code_i;
  logic [31:0] acc_addr_i, snp_addr_i;
  logic        commit_o, abort_o, in_txn_o;
  logic [31:0] abort_status_o;

  typedef struct {
    string       req;
    logic        ab;
    logic [31:0] st;
    logic        cm;
    logic        tx;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;

  txn_set_tracker i_txn_set_tracker (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [31:0] la(input int tag, input int set);
    return {tag[19:0], set[5:0], 6'h00};
  endfunction

  task automatic clr_in();
    begin_i = 0; end_i = 0; abort_i = 0; abort_code_i = '0; debug_hit_i = 0;
    acc_valid_i = 0; acc_write_i = 0; acc_addr_i = '0;
    snp_valid_i = 0; snp_write_i = 0; snp_addr_i = '0;
  endtask

  task automatic acc(input logic wr, input logic [31:0] a);
    acc_valid_i = 1; acc_write_i = wr; acc_addr_i = a;
  endtask

  task automatic snp(input logic wr, input logic [31:0] a);
    snp_valid_i = 1; snp_write_i = wr; snp_addr_i = a;
  endtask

  // driver: push the expected result of this cycle, then advance
  task automatic step(input string req, input logic ab, input logic [31:0] st,
                      input logic cm, input logic tx);
    exp_t e;
    e.req = req; e.ab = ab; e.st = st; e.cm = cm; e.tx = tx;
    exp_q.push_back(e);
    @(negedge clk_i);
    clr_in();
  endtask

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      total++;
      if (abort_o !== e.ab || abort_status_o !== e.st || commit_o !== e.cm || in_txn_o !== e.tx) begin
        bad++;
        $display("FAIL %s: got ab=%0b st=%h cm=%0b tx=%0b exp ab=%0b st=%h cm=%0b tx=%0b",
                 e.req, abort_o, abort_status_o, commit_o, in_txn_o, e.ab, e.st, e.cm, e.tx);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    total++; bad++;
    $display("FAIL watchdog: got hung run exp finished run");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 0; trk_suspend_i = 0; clr_in();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    total++;
    if (abort_o !== 0 || commit_o !== 0 || in_txn_o !== 0 || abort_status_o !== 0) begin
      bad++;
      $display("FAIL R1 reset: got ab=%0b cm=%0b tx=%0b st=%h exp all zero",
               abort_o, commit_o, in_txn_o, abort_status_o);
    end

    // R13 idle ignores everything
    acc(1, la(1, 1)); snp(1, la(1, 1)); abort_i = 1; abort_code_i = 8'h33;
    debug_hit_i = 1; end_i = 1;
    step("R13", 0, 0, 0, 0);

    // R1 R2 basic commit
    begin_i = 1; step("R1", 0, 0, 0, 1);
    step("R1", 0, 0, 0, 1);
    end_i = 1;   step("R2", 0, 0, 1, 0);
    step("R12", 0, 0, 0, 0);
    end_i = 1;   step("R2", 0, 0, 0, 0);

    // R2 nesting
    begin_i = 1; step("R2", 0, 0, 0, 1);
    begin_i = 1; step("R2", 0, 0, 0, 1);
    end_i = 1;   step("R2", 0, 0, 0, 1);
    end_i = 1;   step("R2", 0, 0, 1, 0);

    // R3 R4 fill one set, then overflow
    begin_i = 1; step("R3", 0, 0, 0, 1);
    for (int t = 1; t <= 8; t++) begin
      acc(1, la(t, 5)); step("R3", 0, 0, 0, 1);
    end
    acc(1, la(3, 5) + 32'd7); step("R3", 0, 0, 0, 1);
    acc(0, la(4, 5));         step("R3", 0, 0, 0, 1);
    acc(1, la(9, 5));         step("R4", 1, S_OVF, 0, 0);
    step("R12", 0, 0, 0, 0);

    // R11 tags cleared by abort and by commit
    begin_i = 1; step("R11", 0, 0, 0, 1);
    snp(1, la(1, 5)); step("R11", 0, 0, 0, 1);
    for (int t = 11; t <= 18; t++) begin
      acc(1, la(t, 5)); step("R11", 0, 0, 0, 1);
    end
    end_i = 1;   step("R11", 0, 0, 1, 0);
    begin_i = 1; step("R11", 0, 0, 0, 1);
    snp(1, la(11, 5)); step("R11", 0, 0, 0, 1);

    // R5 conflicts
    acc(0, la(20, 7)); step("R5", 0, 0, 0, 1);
    snp(0, la(20, 7)); step("R5", 0, 0, 0, 1);
    snp(1, la(21, 7)); step("R5", 0, 0, 0, 1);
    snp(1, la(20, 7) + 32'd32); step("R5", 1, S_CONF, 0, 0);
    begin_i = 1; step("R5", 0, 0, 0, 1);
    acc(1, la(22, 9)); step("R5", 0, 0, 0, 1);
    snp(0, la(22, 9)); step("R5", 1, S_CONF, 0, 0);

    // R6 explicit abort, R12 begin in abort cycle, R8 nested
    begin_i = 1; step("R6", 0, 0, 0, 1);
    abort_i = 1; abort_code_i = 8'hA5; step("R6", 1, 32'hA500_0001, 0, 0);
    begin_i = 1; step("R12", 0, 0, 0, 1);
    begin_i = 1; step("R8", 0, 0, 0, 1);
    debug_hit_i = 1; step("R8", 1, 32'h0000_0030, 0, 0);
    begin_i = 1; step("R8", 0, 0, 0, 1);
    begin_i = 1; step("R8", 0, 0, 0, 1);
    abort_i = 1; abort_code_i = 8'h03; step("R8", 1, 32'h0300_0021, 0, 0);

    // R7 debug alone
    begin_i = 1; step("R7", 0, 0, 0, 1);
    debug_hit_i = 1; step("R7", 1, 32'h0000_0010, 0, 0);

    // R9 several causes at once
    begin_i = 1; step("R9", 0, 0, 0, 1);
    acc(1, la(30, 2)); step("R9", 0, 0, 0, 1);
    abort_i = 1; abort_code_i = 8'h11; snp(1, la(30, 2)); debug_hit_i = 1;
    step("R9", 1, 32'h1100_0015, 0, 0);

    // R10 load tracking suspend
    begin_i = 1; step("R10", 0, 0, 0, 1);
    acc(0, la(40, 3)); step("R10", 0, 0, 0, 1);
    trk_suspend_i = 1;
    acc(0, la(41, 3)); step("R10", 0, 0, 0, 1);
    acc(0, la(40, 3)); step("R10", 0, 0, 0, 1);
    snp(1, la(41, 3)); step("R10", 0, 0, 0, 1);
    for (int t = 1; t <= 9; t++) begin
      acc(0, la(t, 4)); step("R10", 0, 0, 0, 1);
    end
    snp(1, la(40, 3)); step("R10", 1, S_CONF, 0, 0);
    begin_i = 1; step("R10", 0, 0, 0, 1);
    acc(1, la(50, 6)); step("R10", 0, 0, 0, 1);
    snp(0, la(50, 6)); step("R10", 1, S_CONF, 0, 0);
    trk_suspend_i = 0;

    @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule